// File: doc/BRIEF.md
# Time-Aware Transmit Gate Scheduler

This block runs a gate control list for a transmit port with eight priorities. Each list entry is a 22-bit command. The command carries a duration in line clocks and an 8-bit allow mask, where a set bit lets that priority fetch frames. An external time base issues a periodic cycle-start pulse. On each pulse the block walks the operational list from its first entry. It drives each entry's mask on the gate output for exactly that entry's count of clocks, then moves to the next entry.

The 128-entry command store can work as one long list or as two 64-entry banks. In two-bank mode one bank is operational while software loads the other. A swap request takes effect only at the next cycle start. A global round-robin flag or a low enable forces every priority open. Durations longer than one command can hold are written as consecutive commands with the same mask.

Top module: `tas_gate_sched`

## Requirements
- R1: During reset and whenever `enable` is low, the clock edge drives `gate` to all ones and `cur_idx` to 0. Reset also clears `active_bank` and `overrun` and zeroes every command.
- R2: While `rr_mode` is high, `gate` is all ones and `cur_idx` is 0 from the next edge on. Cycle-start pulses have no effect on the walk in this state.
- R3: A command word holds its count in bits 21:8 and its mask in bits 7:0. Bit i of `gate` equals mask bit i and allows priority i.
- R4: A cycle-start pulse sampled at an edge makes the first command's mask visible right after that edge. Each nonzero-count command's mask is shown for exactly count clocks before the next command's mask appears.
- R5: Consecutive commands with the same mask give one unbroken interval whose length is the sum of their counts.
- R6: A command with count 0 ends the list. `cur_idx` moves to that entry, and `gate` keeps the last mask it drove until the next cycle start.
- R7: The list also ends once the last entry of the list has run out. That entry is index 63 in two-bank mode and index 127 in single-list mode. `cur_idx` and `gate` then hold.
- R8: Every accepted cycle-start pulse restarts the walk at index 0 of the operational list, even when the walk is in mid-list.
- R9: `overrun` becomes 1 when a cycle start arrives while the walk has not finished, which includes the final command's last clock. It then stays at 1 until reset. A start after the list has ended leaves it unchanged.
- R10: A `swap_req` pulse is held pending. In two-bank mode the pending swap toggles `active_bank` only at the next accepted cycle start, and the walk that starts there already uses the new bank. `active_bank` never changes at any other time.
- R11: In single-list mode (`split_mode` = 0) the list starts at address 0 and spans all 128 entries, whatever the value of `active_bank`.
- R12: A write puts `wr_data` at the absolute address `wr_addr`. Bank 1 occupies addresses 64 to 127 in two-bank mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-side clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Gating enable |
| rr_mode | input | 1 | Global round-robin flag; forces all priorities open |
| split_mode | input | 1 | 1: two 64-entry banks, 0: one 128-entry list |
| cycle_start | input | 1 | Cycle-start pulse from the time base |
| swap_req | input | 1 | Request a bank swap at the next cycle start |
| wr_en | input | 1 | Command write strobe |
| wr_addr | input | 7 | Absolute command address |
| wr_data | input | 22 | Command word {count[13:0], mask[7:0]} |
| gate | output | 8 | Per-priority fetch allow |
| cur_idx | output | 7 | Index of the current command within the operational list |
| active_bank | output | 1 | Operational bank in two-bank mode |
| overrun | output | 1 | Sticky flag: a cycle start cut a walk short |

## Verification
Two events can fall in the same clock: a cycle start and the advance from one command to the next. A cycle start can also coincide with an applied bank swap. The bench issues a restart in mid-list and checks that the walk returns to index 0 and that the overrun flag rises. It also leaves a swap pending across a cycle start and checks that the first mask comes from the new bank. A behavioural reference model runs beside the design and compares all four outputs on every clock.

// File: rtl/tas_pkg.sv
package tas_pkg;
    localparam int CNT_W  = 14;
    localparam int MASK_W = 8;
    localparam int CMD_W  = CNT_W + MASK_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [MASK_W-1:0] mask;
    } gcl_cmd_t;

    function automatic gcl_cmd_t to_cmd(input logic [CMD_W-1:0] word);
        return gcl_cmd_t'(word);
    endfunction
endpackage

// File: rtl/tas_cmd_mem.sv
module tas_cmd_mem
    import tas_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output gcl_cmd_t         rd_cmd
);
    logic [CMD_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_en) begin
            store[wr_addr] <= wr_data;
        end
    end

    assign rd_cmd = to_cmd(store[rd_addr]);
endmodule

// File: rtl/tas_bank_ctl.sv
module tas_bank_ctl (
    input  logic clk,
    input  logic rst,
    input  logic split_mode,
    input  logic swap_req,
    input  logic start_act,
    output logic active_bank,
    output logic rd_bank
);
    logic pending;
    logic flip;

    assign flip    = start_act & pending & split_mode;
    assign rd_bank = active_bank ^ flip;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_bank <= 1'b0;
            pending     <= 1'b0;
        end else begin
            active_bank <= rd_bank;
            pending     <= swap_req | (pending & ~start_act);
        end
    end
endmodule

// File: rtl/tas_gate_walker.sv
module tas_gate_walker
    import tas_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH),
    localparam int HALF = DEPTH / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              start,
    input  logic              split_mode,
    input  logic              rd_bank,
    input  gcl_cmd_t          rd_cmd,
    output logic [AW-1:0]     rd_addr,
    output logic [MASK_W-1:0] gate,
    output logic [AW-1:0]     cur_idx,
    output logic              overrun
);
    logic [CNT_W-1:0] remain, n_remain;
    logic [AW-1:0]    n_idx, nxt_idx;
    logic [MASK_W-1:0] n_gate;
    logic             busy, n_busy;
    logic             at_last;

    assign nxt_idx = start ? '0 : cur_idx + AW'(1);
    assign at_last = split_mode ? (cur_idx == AW'(HALF - 1)) : (cur_idx == AW'(DEPTH - 1));
    assign rd_addr = split_mode ? {rd_bank, nxt_idx[AW-2:0]} : nxt_idx;

    always_comb begin
        n_idx    = cur_idx;
        n_remain = remain;
        n_gate   = gate;
        n_busy   = busy;
        if (start || (busy && remain == '0 && !at_last)) begin
            n_idx = nxt_idx;
            if (rd_cmd.count == '0) begin
                n_busy = 1'b0;
            end else begin
                n_gate   = rd_cmd.mask;
                n_remain = rd_cmd.count - CNT_W'(1);
                n_busy   = 1'b1;
            end
        end else if (busy && remain != '0) begin
            n_remain = remain - CNT_W'(1);
        end else if (busy) begin
            n_busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cur_idx <= '0;
            remain  <= '0;
            gate    <= '1;
            busy    <= 1'b0;
        end else begin
            cur_idx <= n_idx;
            remain  <= n_remain;
            gate    <= n_gate;
            busy    <= n_busy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                overrun <= 1'b0;
        else if (start && busy) overrun <= 1'b1;
    end
endmodule

// File: rtl/tas_gate_sched.sv
module tas_gate_sched
    import tas_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              rr_mode,
    input  logic              split_mode,
    input  logic              cycle_start,
    input  logic              swap_req,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [CMD_W-1:0]  wr_data,
    output logic [MASK_W-1:0] gate,
    output logic [AW-1:0]     cur_idx,
    output logic              active_bank,
    output logic              overrun
);
    logic     active, start_act, rd_bank;
    logic [AW-1:0] rd_addr;
    gcl_cmd_t rd_cmd;

    assign active    = enable & ~rr_mode;
    assign start_act = cycle_start & active;

    tas_cmd_mem #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_cmd(rd_cmd)
    );

    tas_bank_ctl u_bank (
        .clk(clk), .rst(rst), .split_mode(split_mode), .swap_req(swap_req),
        .start_act(start_act), .active_bank(active_bank), .rd_bank(rd_bank)
    );

    tas_gate_walker #(.DEPTH(DEPTH)) u_walk (
        .clk(clk), .rst(rst), .active(active), .start(start_act),
        .split_mode(split_mode), .rd_bank(rd_bank), .rd_cmd(rd_cmd),
        .rd_addr(rd_addr), .gate(gate), .cur_idx(cur_idx), .overrun(overrun)
    );
endmodule

// File: rtl/tas_gate_sched_chk.sv
module tas_gate_sched_chk #(
    parameter int AW = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          enable,
    input logic          rr_mode,
    input logic          cycle_start,
    input logic [7:0]    gate,
    input logic [AW-1:0] cur_idx,
    input logic          active_bank,
    input logic          overrun
);
    // R1
    disabled_open_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (gate == 8'hFF && cur_idx == '0));

    // R2
    rr_open_chk: assert property (@(posedge clk) disable iff (rst)
        rr_mode |=> (gate == 8'hFF && cur_idx == '0));

    // R8
    restart_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_start && enable && !rr_mode) |=> (cur_idx == '0));

    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R10
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cycle_start |=> $stable(active_bank));
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .enable(enable), .rr_mode(rr_mode),
    .cycle_start(cycle_start), .gate(gate), .cur_idx(cur_idx),
    .active_bank(active_bank), .overrun(overrun)
);

// File: tb/tb_tas_gate_sched.sv
module tb_tas_gate_sched;
    logic        clk = 0;
    logic        rst = 1;
    logic        enable = 0, rr_mode = 0, split_mode = 0;
    logic        cycle_start = 0, swap_req = 0, wr_en = 0;
    logic [6:0]  wr_addr = 0;
    logic [21:0] wr_data = 0;
    logic [7:0]  gate;
    logic [6:0]  cur_idx;
    logic        active_bank, overrun;

    int tests = 0, fails = 0, cyc = 0;
    bit started = 0;

    always #5 clk = ~clk;

    tas_gate_sched dut (
        .clk(clk), .rst(rst), .enable(enable), .rr_mode(rr_mode),
        .split_mode(split_mode), .cycle_start(cycle_start), .swap_req(swap_req),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gate(gate), .cur_idx(cur_idx), .active_bank(active_bank), .overrun(overrun)
    );

    // behavioural reference model
    int m_mem [128];
    int m_idx, m_rem, m_mask, m_busy, m_bank, m_pend, m_ovr;

    task automatic m_load();
        int a, c;
        a = split_mode ? m_bank * 64 + m_idx : m_idx;
        c = m_mem[a] / 256;
        if (c == 0) m_busy = 0;
        else begin
            m_mask = m_mem[a] % 256;
            m_rem  = c - 1;
            m_busy = 1;
        end
    endtask

    always @(posedge clk) begin
        int act, st, lastn;
        started = 1;
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_idx = 0; m_rem = 0; m_mask = 255; m_busy = 0;
            m_bank = 0; m_pend = 0; m_ovr = 0;
        end else begin
            act = enable && !rr_mode;
            st  = cycle_start && act;
            if (st && m_pend && split_mode) m_bank = 1 - m_bank;
            m_pend = swap_req || (m_pend && !st);
            lastn = split_mode ? 63 : 127;
            if (!act) begin
                m_idx = 0; m_rem = 0; m_mask = 255; m_busy = 0;
            end else if (st) begin
                if (m_busy) m_ovr = 1;
                m_idx = 0;
                m_load();
            end else if (m_busy) begin
                if (m_rem > 0) m_rem--;
                else if (m_idx == lastn) m_busy = 0;
                else begin
                    m_idx++;
                    m_load();
                end
            end
            if (wr_en) m_mem[wr_addr] = wr_data;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            tests++;
            if (gate !== 8'(m_mask) || cur_idx !== 7'(m_idx) ||
                active_bank !== 1'(m_bank) || overrun !== 1'(m_ovr)) begin
                fails++;
                $display("FAIL R4 model compare: act gate=%h idx=%0d bank=%0d ovr=%0d exp gate=%h idx=%0d bank=%0d ovr=%0d",
                         gate, cur_idx, active_bank, overrun, m_mask, m_idx, m_bank, m_ovr);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++;
            $display("FAIL watchdog: act cycles=%0d exp <20000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int cnt, input int m);
        wr_en = 1; wr_addr = 7'(a); wr_data = {14'(cnt), 8'(m)};
        tick();
        wr_en = 0;
    endtask

    task automatic pulse_start();
        cycle_start = 1;
        tick();
        cycle_start = 0;
    endtask

    initial begin
        repeat (3) tick();
        // R1 reset state
        chk(gate == 8'hFF, "R1 gate", gate, 8'hFF);
        chk(cur_idx == 0 && active_bank == 0 && overrun == 0, "R1 idx/bank/ovr", cur_idx, 0);
        rst = 0; enable = 1; split_mode = 1;
        wr(0, 3, 8'h0F); wr(1, 2, 8'hF0); wr(2, 0, 0);
        pulse_start();
        chk(gate == 8'h0F, "R3 first mask", gate, 8'h0F);
        tick(); tick();
        chk(gate == 8'h0F, "R4 held count", gate, 8'h0F);
        tick();
        chk(gate == 8'hF0, "R4 next entry", gate, 8'hF0);
        tick(); tick();
        chk(gate == 8'hF0 && cur_idx == 2, "R6 terminator hold", cur_idx, 2);
        repeat (3) tick();
        chk(gate == 8'hF0 && cur_idx == 2, "R6 still held", gate, 8'hF0);
        pulse_start();
        chk(overrun == 0, "R9 no overrun after end", overrun, 0);
        chk(gate == 8'h0F && cur_idx == 0, "R8 restart", gate, 8'h0F);
        repeat (8) tick();
        wr(0, 2, 8'hAA); wr(1, 3, 8'hAA); wr(2, 1, 8'h55); wr(3, 0, 0);
        pulse_start();
        for (int k = 1; k <= 5; k++) begin
            chk(gate == 8'hAA, "R5 merged interval", gate, 8'hAA);
            tick();
        end
        chk(gate == 8'h55, "R5 after merge", gate, 8'h55);
        tick();
        pulse_start();
        tick();
        pulse_start();
        chk(overrun == 1, "R9 overrun set", overrun, 1);
        chk(cur_idx == 0 && gate == 8'hAA, "R8 mid-list restart", cur_idx, 0);
        tick();
        chk(overrun == 1, "R9 sticky", overrun, 1);
        rr_mode = 1;
        tick();
        chk(gate == 8'hFF && cur_idx == 0, "R2 round robin open", gate, 8'hFF);
        pulse_start();
        chk(gate == 8'hFF && cur_idx == 0, "R2 start ignored", gate, 8'hFF);
        rr_mode = 0;
        tick();
        wr(64, 2, 8'h33); wr(65, 0, 0);
        pulse_start();
        tick();
        swap_req = 1;
        tick();
        swap_req = 0;
        chk(active_bank == 0, "R10 no mid-cycle swap", active_bank, 0);
        chk(gate == 8'hAA, "R10 gate unaffected", gate, 8'hAA);
        repeat (6) tick();
        pulse_start();
        chk(active_bank == 1, "R10 swap at start", active_bank, 1);
        chk(gate == 8'h33, "R12 bank1 absolute write", gate, 8'h33);
        tick(); tick();
        chk(gate == 8'h33 && cur_idx == 1, "R6 bank1 terminator", cur_idx, 1);
        for (int i = 0; i < 128; i++) wr(i, 1, i);
        pulse_start();
        chk(gate == 8'h40 && cur_idx == 0, "R12 bank1 base", gate, 8'h40);
        repeat (68) tick();
        chk(gate == 8'h7F && cur_idx == 63, "R7 split bank end", cur_idx, 63);
        split_mode = 0;
        tick();
        pulse_start();
        chk(gate == 8'h00 && cur_idx == 0, "R11 single base", gate, 8'h00);
        repeat (64) tick();
        chk(gate == 8'h40 && cur_idx == 64, "R11 past 64", cur_idx, 64);
        repeat (70) tick();
        chk(gate == 8'h7F && cur_idx == 127, "R7 single end", cur_idx, 127);
        enable = 0;
        tick();
        chk(gate == 8'hFF && cur_idx == 0, "R1 disabled open", gate, 8'hFF);
        chk(overrun == 1, "R9 kept while disabled", overrun, 1);
        tick();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule